// File: doc/BRIEF.md
# Selectable-Source Watch Timer

This block produces a periodic real-time tick for a chip that must keep time while it runs, waits or sleeps. The count source is chosen in a mode register. One choice is a slow external watch clock of 32.768 kHz. The other is a path derived from the system clock: the system clock is divided by a fixed prescaler, and then optionally by 3. The divide-by-3 step lets either of two system clock rates yield the same 32.768 kHz count rate.

The selected count pulses drive a binary ripple of `STAGES` stages. A tick is taken from the last stage for the normal period, which is half a second with the default sizes. In fast-forward mode the tick is taken from a low stage (`FAST_TAP`), which shortens the period by a factor of 2^(STAGES-FAST_TAP). That factor is 512 with the defaults.

Each tick gives a one-cycle pulse on `tickOut` and sets a sticky request flag. Software clears the flag by writing 0 to it. Counting from the system-clock path pauses in the deep standby states. Counting from the watch clock never pauses.

All logic runs on `clk`. Watch-clock edges pass through a two-flop synchronizer, so `clk` must run at more than twice the watch-clock rate.

Top module: `watch_tick_timer`

## Requirements
- R1: After reset, `tickOut`, `irqFlag` and `oscEn` are 0, and every mode bit is 0. With every mode bit at 0, the timer is stopped.
- R2: A write on `modeWe` loads the mode register from `modeWdata` on that edge. The bit positions are: bit 7 turns the watch oscillator on, bit 6 selects the source (0 = system path, 1 = watch clock), bit 3 selects fast-forward, bit 2 runs the timer, and bit 0 bypasses the divide-by-3. Bits 5, 4 and 1 are ignored. `oscEn` follows bit 7 from the next cycle on.
- R3: With the system path, the divide-by-3 bypassed and normal mode, ticks repeat every `PRE_DIV`·2^`STAGES` clocks. The first tick after the run bit goes from 0 to 1 arrives exactly one period after the write edge.
- R4: With the system path and the divide-by-3 in use (bit 0 = 0), every period is three times the bypassed period.
- R5: Fast-forward mode (bit 3 = 1) divides the period by 2^(`STAGES`-`FAST_TAP`), with either source.
- R6: With the watch-clock source and bit 7 = 1, the counter advances once per synchronized rising edge of `wcIn`. The normal period is 2^`STAGES` such edges. With bit 7 = 0, no tick is produced.
- R7: With the system-path source, `standby` = 1 (halt) does not slow counting. `standby` = 2 (stop) or 3 (idle) freezes the prescaler, the divide-by-3 and the counter. Counting resumes from the same state afterwards.
- R8: With the watch-clock source, the tick period is the same in every `standby` state.
- R9: `tickOut` is high for exactly one cycle per tick. `irqFlag` is 1 in the same cycle.
- R10: `irqFlag` stays set until a write on `icWe` with `icFlagWr` = 0 clears it on that edge. A write with `icFlagWr` = 1 has no effect. When a tick and a clear fall on the same edge, the flag ends up set.
- R11: While the run bit is 0, the counter and the system-path dividers are held at zero and no tick occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wcIn | input | 1 | Watch clock, asynchronous to clk |
| modeWe | input | 1 | Mode register write strobe |
| modeWdata | input | 8 | Mode register write value |
| icWe | input | 1 | Request-flag write strobe |
| icFlagWr | input | 1 | Value written to the request flag (0 clears) |
| standby | input | 2 | 0 run, 1 halt, 2 stop, 3 idle |
| oscEn | output | 1 | Watch oscillator enable |
| tickOut | output | 1 | One-cycle tick pulse |
| irqFlag | output | 1 | Sticky tick request flag |

## Verification
On the system path, a count step and the prescaler wrap land on the same edge. The tick and the flag therefore appear on the edge that makes the 2^k-th count: `PRE_DIV`·2^k edges after the mode write when the divide-by-3 is bypassed. Any stall cycles in stop or idle are added to that count. The first-tick, standby and collision checks count negative edges from the negedge that follows the write edge, and they expect the tick in exactly that numbered negedge. A flag write takes effect on its own edge and is read at the following negedge. Steady periods are compared as intervals between successive ticks: the tick that follows a mode change is discarded, so the phase left from the previous mode does not affect the result.

// File: rtl/wt_pkg.sv
package wt_pkg;

  // mode register bit positions (software-visible encoding)
  localparam int MODE_OSC  = 7;
  localparam int MODE_SRC  = 6;
  localparam int MODE_FAST = 3;
  localparam int MODE_RUN  = 2;
  localparam int MODE_BYP  = 0;

  typedef enum logic [1:0] {
    SB_RUN  = 2'd0,
    SB_HALT = 2'd1,
    SB_STOP = 2'd2,
    SB_IDLE = 2'd3
  } standby_e;

  typedef struct packed {
    logic oscOn;
    logic srcWatch;
    logic fast;
    logic run;
    logic bypass;
  } modeReg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;
    logic step;
    logic fast;
    logic flagClr;
  } wtStrobe_t;

endpackage

// File: rtl/wt_ctrl.sv
module wt_ctrl
  import wt_pkg::*;
#(
  parameter int PRE_DIV = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wcIn,
  input  logic       modeWe,
  input  logic [7:0] modeWdata,
  input  logic       icWe,
  input  logic       icFlagWr,
  input  logic [1:0] standby,
  output modeReg_t   modeQ,
  output wtStrobe_t  strb
);

  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic       unusedModeBits;
  logic [2:0] wcSync;
  logic       wcRise;
  standby_e   sb;
  logic       deepSleep;
  logic       mainAct;
  logic       prePulse;
  logic [1:0] d3Cnt;
  logic       d3Pulse;
  logic       watchStep;

  assign unusedModeBits = ^{modeWdata[5:4], modeWdata[1]};

  // mode register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
    end else if (modeWe) begin
      modeQ <= '{oscOn:    modeWdata[MODE_OSC],
                 srcWatch: modeWdata[MODE_SRC],
                 fast:     modeWdata[MODE_FAST],
                 run:      modeWdata[MODE_RUN],
                 bypass:   modeWdata[MODE_BYP]};
    end
  end

  // watch clock: two synchronizer flops plus one edge reference flop
  always_ff @(posedge clk) begin
    if (!rstN) wcSync <= '0;
    else       wcSync <= {wcSync[1:0], wcIn};
  end
  assign wcRise = wcSync[1] & ~wcSync[2];

  assign sb        = standby_e'(standby);
  assign deepSleep = (sb == SB_STOP) || (sb == SB_IDLE);
  assign mainAct   = modeQ.run && !modeQ.srcWatch && !deepSleep;

  // fixed system-clock prescaler
  generate
    if (PRE_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !modeQ.run) preCnt <= '0;
        else if (mainAct)        preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
      end
      assign prePulse = mainAct && (preCnt == PRE_LAST);
    end else begin : g_nopre
      assign prePulse = mainAct;
    end
  endgenerate

  // optional divide-by-3
  always_ff @(posedge clk) begin
    if (!rstN || !modeQ.run)             d3Cnt <= '0;
    else if (prePulse && !modeQ.bypass)  d3Cnt <= (d3Cnt == 2'd2) ? 2'd0 : d3Cnt + 2'd1;
  end
  assign d3Pulse = prePulse && (modeQ.bypass || (d3Cnt == 2'd2));

  assign watchStep = modeQ.run && modeQ.srcWatch && modeQ.oscOn && wcRise;

  always_comb begin
    strb.clr     = !modeQ.run;
    strb.step    = d3Pulse | watchStep;
    strb.fast    = modeQ.fast;
    strb.flagClr = icWe && !icFlagWr;
  end

endmodule

// File: rtl/wt_datapath.sv
module wt_datapath
  import wt_pkg::*;
#(
  parameter int STAGES   = 14,
  parameter int FAST_TAP = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  wtStrobe_t         strb,
  output logic [STAGES-1:0] cntQ,
  output logic              tickOut,
  output logic              irqFlag
);

  logic tapNorm;
  logic tapFast;
  logic tick;

  generate
    if (FAST_TAP < 1 || FAST_TAP >= STAGES) begin : g_badTap
      $error("FAST_TAP must lie in 1..STAGES-1");
    end
  endgenerate

  // carry out of the last stage, or of stage FAST_TAP
  assign tapNorm = &cntQ;
  assign tapFast = &cntQ[FAST_TAP-1:0];
  assign tick    = strb.step && (strb.fast ? tapFast : tapNorm);

  always_ff @(posedge clk) begin
    if (!rstN || strb.clr) cntQ <= '0;
    else if (strb.step)    cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) tickOut <= 1'b0;
    else       tickOut <= tick;
  end

  // tick has priority over a clear on the same edge
  always_ff @(posedge clk) begin
    if (!rstN)             irqFlag <= 1'b0;
    else if (tick)         irqFlag <= 1'b1;
    else if (strb.flagClr) irqFlag <= 1'b0;
  end

endmodule

// File: rtl/watch_tick_timer.sv
module watch_tick_timer
  import wt_pkg::*;
#(
  parameter int PRE_DIV  = 128,
  parameter int STAGES   = 14,
  parameter int FAST_TAP = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wcIn,
  input  logic       modeWe,
  input  logic [7:0] modeWdata,
  input  logic       icWe,
  input  logic       icFlagWr,
  input  logic [1:0] standby,
  output logic       oscEn,
  output logic       tickOut,
  output logic       irqFlag
);

  modeReg_t          modeQ;
  wtStrobe_t         strb;
  logic [STAGES-1:0] cntQ;

  wt_ctrl #(.PRE_DIV(PRE_DIV)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wcIn      (wcIn),
    .modeWe    (modeWe),
    .modeWdata (modeWdata),
    .icWe      (icWe),
    .icFlagWr  (icFlagWr),
    .standby   (standby),
    .modeQ     (modeQ),
    .strb      (strb)
  );

  wt_datapath #(.STAGES(STAGES), .FAST_TAP(FAST_TAP)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cntQ    (cntQ),
    .tickOut (tickOut),
    .irqFlag (irqFlag)
  );

  assign oscEn = modeQ.oscOn;

endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int STAGES = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeRun,
  input logic              modeSrc,
  input logic [1:0]        standby,
  input logic              icWe,
  input logic              icFlagWr,
  input logic              tickOut,
  input logic              irqFlag,
  input logic [STAGES-1:0] cntQ
);

  // R9
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |=> !tickOut);

  // R9
  tick_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> irqFlag);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqFlag) |-> $past(icWe && !icFlagWr));

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> tickOut);

  // R11
  halted_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeRun |=> !tickOut);

  // R11
  halted_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeRun |=> (cntQ == '0));

  // R7
  deep_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeRun && !modeSrc && standby[1]) |=> $stable(cntQ));

endmodule

bind watch_tick_timer wt_checker #(.STAGES(STAGES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .modeRun  (modeQ.run),
  .modeSrc  (modeQ.srcWatch),
  .standby  (standby),
  .icWe     (icWe),
  .icFlagWr (icFlagWr),
  .tickOut  (tickOut),
  .irqFlag  (irqFlag),
  .cntQ     (cntQ)
);

// File: tb/watch_tick_timer_test.sv
`timescale 1ns/1ps
module watch_tick_timer_test;

  localparam int PD = 4;
  localparam int ST = 6;
  localparam int FT = 2;
  localparam int NORM_BYP  = PD * (1 << ST);        // 256
  localparam int FAST_BYP  = PD * (1 << FT);        // 16
  localparam int WC_EDGE   = 20;                    // clocks per watch-clock period
  localparam int WC_NORM   = WC_EDGE * (1 << ST);   // 1280
  localparam int WC_FAST   = WC_EDGE * (1 << FT);   // 80

  logic       clk = 0;
  logic       rstN = 0;
  logic       wcIn = 0;
  logic       modeWe = 0;
  logic [7:0] modeWdata = '0;
  logic       icWe = 0;
  logic       icFlagWr = 1;
  logic [1:0] standby = 2'd0;
  logic       oscEn, tickOut, irqFlag;

  int errCnt = 0;
  int chkCnt = 0;

  // scoreboard state
  int    expQ[$];
  string curTag = "";
  int    cyc = 0;
  int    lastTick = 0;
  bit    haveLast = 0;

  watch_tick_timer #(.PRE_DIV(PD), .STAGES(ST), .FAST_TAP(FT)) uut (
    .clk(clk), .rstN(rstN), .wcIn(wcIn), .modeWe(modeWe), .modeWdata(modeWdata),
    .icWe(icWe), .icFlagWr(icFlagWr), .standby(standby),
    .oscEn(oscEn), .tickOut(tickOut), .irqFlag(irqFlag)
  );

  always #5 clk = ~clk;
  always #100 wcIn = ~wcIn;

  task automatic check(bit ok, string req, int act, int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares tick intervals with the queued expectations
  always @(negedge clk) begin
    cyc++;
    if (tickOut === 1'b1 && expQ.size() > 0) begin
      if (haveLast) begin
        int e;
        e = expQ.pop_front();
        check((cyc - lastTick) == e, curTag, cyc - lastTick, e);
      end
      haveLast = 1;
      lastTick = cyc;
    end
  end

  task automatic measure(int per, int n, string tag);
    @(posedge clk); #1;
    haveLast = 0;
    curTag = tag;
    for (int i = 0; i < n; i++) expQ.push_back(per);
    while (expQ.size() > 0) @(negedge clk);
  endtask

  task automatic writeMode(logic [7:0] v);
    @(negedge clk); modeWe = 1; modeWdata = v;
    @(negedge clk); modeWe = 0;
  endtask

  task automatic writeFlag(logic v);
    @(negedge clk); icWe = 1; icFlagWr = v;
    @(negedge clk); icWe = 0; icFlagWr = 1;
  endtask

  task automatic waitTick(output int n);
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (tickOut !== 1'b1 && n < 20000);
  endtask

  task automatic countTicks(int cycles, output int k);
    k = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tickOut === 1'b1) k++;
    end
  endtask

  task automatic stallRun(logic [1:0] sbVal, int expWait, string tag);
    int n;
    writeMode(8'h00);
    writeMode(8'h05);
    repeat (50) @(negedge clk);
    standby = sbVal;
    repeat (100) @(negedge clk);
    standby = 2'd0;
    waitTick(n);
    check(n == expWait, tag, n, expWait);
  endtask

  initial begin
    #2_000_000;
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    int n, k;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tickOut == 0, "R1 tickOut", tickOut, 0);
    check(irqFlag == 0, "R1 irqFlag", irqFlag, 0);
    check(oscEn == 0, "R1 oscEn", oscEn, 0);
    rstN = 1;
    countTicks(300, k);
    check(k == 0, "R1 stopped after reset", k, 0);

    // R2 oscillator bit and ignored bits
    writeMode(8'hB2);
    check(oscEn == 1, "R2 oscEn set", oscEn, 1);
    countTicks(400, k);
    check(k == 0, "R2 bits 5,4,1 ignored", k, 0);
    writeMode(8'h00);
    check(oscEn == 0, "R2 oscEn clear", oscEn, 0);

    // R3 first tick after enable, R9 pulse width and flag
    writeMode(8'h05);
    waitTick(n);
    check(n == NORM_BYP, "R3 first tick", n, NORM_BYP);
    check(irqFlag == 1, "R9 flag with tick", irqFlag, 1);
    @(negedge clk);
    check(tickOut == 0, "R9 single-cycle tick", tickOut, 0);
    measure(NORM_BYP, 3, "R3 bypass period");

    // R10 flag write behaviour
    writeFlag(1'b1);
    check(irqFlag == 1, "R10 write 1 ignored", irqFlag, 1);
    writeFlag(1'b0);
    check(irqFlag == 0, "R10 clear", irqFlag, 0);
    repeat (20) @(negedge clk);
    check(irqFlag == 0, "R10 stays clear", irqFlag, 0);

    // R10 tick and clear on the same edge
    writeMode(8'h00);
    writeMode(8'h0D);
    repeat (FAST_BYP - 1) @(negedge clk);
    icWe = 1; icFlagWr = 0;
    @(negedge clk);
    icWe = 0; icFlagWr = 1;
    check(tickOut == 1, "R10 collision tick", tickOut, 1);
    check(irqFlag == 1, "R10 tick wins", irqFlag, 1);

    // R5 fast mode, R4 divide-by-3
    measure(FAST_BYP, 3, "R5 fast bypass");
    writeMode(8'h0C);
    measure(3 * FAST_BYP, 3, "R5 R4 fast div3");
    writeMode(8'h04);
    measure(3 * NORM_BYP, 2, "R4 div3 normal");

    // R7 standby gating on the system path
    stallRun(2'd2, NORM_BYP - 50, "R7 stop freezes");
    stallRun(2'd3, NORM_BYP - 50, "R7 idle freezes");
    stallRun(2'd1, NORM_BYP - 150, "R7 halt runs");

    // R6 watch source, R8 standby independence
    writeMode(8'hC4);
    measure(WC_NORM, 2, "R6 watch normal");
    writeMode(8'hCC);
    measure(WC_FAST, 3, "R6 R5 watch fast");
    standby = 2'd2;
    measure(WC_FAST, 3, "R8 watch in stop");
    standby = 2'd3;
    measure(WC_FAST, 2, "R8 watch in idle");
    standby = 2'd0;

    // R6 oscillator off
    writeMode(8'h4C);
    countTicks(500, k);
    check(k == 0, "R6 osc off no tick", k, 0);

    // R11 run bit low
    writeMode(8'h09);
    countTicks(600, k);
    check(k == 0, "R11 halted no tick", k, 0);
    writeMode(8'h0D);
    waitTick(n);
    check(n == FAST_BYP, "R11 restart from zero", n, FAST_BYP);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule